// File: doc/BRIEF.md
# Layered Min-Sum Check Node Lane

This block is one lane of a layered low-density parity-check decoder. It handles one column position out of the lane count. Each clock it takes up to three edges of the check node being processed, one from each slot. For every edge it removes the message that this check node left on that edge during the previous visit, which gives the variable-to-check value. It folds all live edges of the beat into one running search that tracks the two smallest magnitudes, the position of the smallest, and the sign product. Once the closing beat of the check node has arrived, the block replays the same beats in the same order, one per clock. On each replayed beat it outputs the new check-to-variable message (normalized by 7/8) and the refreshed a-posteriori value for every live edge. It also writes each new message back into its own per-edge store.

Collection and replay run as two separate passes over a pair of beat buffers, so the next check node can be collected while the previous one is still being replayed. A decoder controller drives the edges through a store address for each beat. It asks for the first-iteration view when messages from an earlier codeword must not be used. It gathers the per-check parity bit to decide whether to stop early.

Top module: `mslayer_cnb`

## Requirements
- R1: After reset, no output beat is presented (`out_beat`, `out_end`, `out_vld`, `out_parity` all 0), and every stored message reads as zero.
- R2: For each live edge the variable-to-check value is the incoming a-posteriori value minus the stored message at (`in_addr`, slot), clamped to ±63. When `in_first_iter` is 1 the stored message counts as zero.
- R3: The output message magnitude of an edge is the smallest variable-to-check magnitude among the other edges of the check node, m, reduced to m − (m >> 3) and then capped at 31.
- R4: The output message is negative exactly when the XOR of the sign bits (1 = negative, zero counts as positive) of the other edges' variable-to-check values is 1.
- R5: The refreshed a-posteriori value of an edge is its variable-to-check value plus its new message, clamped to ±63.
- R6: A slot with `in_vld` low in a beat has no effect on the minima, the sign product or the parity. On replay its `out_vld` is 0 and its `out_app` and `out_c2c` are 0. Its stored message is left unchanged.
- R7: On the final replayed beat, `out_parity` equals the XOR of the sign bits of the incoming a-posteriori values over all live edges. On every other cycle it is 0.
- R8: Replay starts in the cycle right after the closing beat is accepted. It presents one beat per cycle with no gaps, in the order of collection, and marks the last one with `out_end`. Input cycles with `in_beat` low are ignored whatever the other inputs carry.
- R9: The message produced for an edge is stored at its (`in_addr`, slot) and is used as the subtrahend the next time that address is collected.
- R10: A check node spans at most 5 beats. A new check node may be collected while the previous one replays, provided its closing beat is accepted no earlier than the cycle that shows the previous replay's last beat.
- R11: Saturation is symmetric: a live `out_app` is never −64 and a live `out_c2c` is never −32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_beat | input | 1 | A collection beat is present this cycle |
| in_start | input | 1 | This beat opens a check node |
| in_end | input | 1 | This beat closes a check node |
| in_first_iter | input | 1 | Treat the stored messages as zero for this beat |
| in_addr | input | 5 | Message store address of this beat |
| in_vld | input | 3 | Per-slot live edge flags |
| in_app | input | 3x7 | Per-slot a-posteriori values, two's complement |
| out_beat | output | 1 | A replay beat is presented |
| out_end | output | 1 | Last replay beat of the check node |
| out_vld | output | 3 | Per-slot live edge flags of the replay beat |
| out_app | output | 3x7 | Per-slot refreshed a-posteriori values |
| out_c2c | output | 3x6 | Per-slot new check-to-variable messages |
| out_parity | output | 1 | Hard-decision parity of the check node, on the last beat |

## Verification
The bound checker watches the replay framing on every cycle. It checks that a closing beat is followed at once by a replay beat, that replay beats are contiguous up to `out_end`, that idle slots output zeros, that saturation never reaches the asymmetric code, and that the beat-count and overlap limits hold. The arithmetic cannot be seen from a single cycle: the minimum excluding the edge's own value, the sign product, the 7/8 scaling, the parity, and the reuse of stored messages on the next visit. The bench sweeps check degrees 5 to 15 over many rounds with shuffled idle slots, ties, extreme values, mid-node gaps and first-iteration passes, and compares every replayed edge against its own arithmetic model.

// File: rtl/cnb_pkg.sv
package cnb_pkg;

   // clamp to the symmetric range [-lim, +lim]
   function automatic int clamp_sym(input int x, input int lim);
      if (x > lim) return lim;
      if (x < -lim) return -lim;
      return x;
   endfunction

   // normalization x - x/2^sh, x non-negative
   function automatic int norm_mag(input int x, input int sh);
      return x - (x >>> sh);
   endfunction

endpackage

// File: rtl/cnb_v2c.sv
module cnb_v2c
   import cnb_pkg::*;
#(
   parameter int APP_W = 7,
   parameter int MSG_W = 6
) (
   input  logic signed [APP_W-1:0] app_i,
   input  logic signed [MSG_W-1:0] msg_i,
   input  logic                    ign_msg_i,
   output logic signed [APP_W-1:0] v2c_o,
   output logic [APP_W-2:0]        mag_o,
   output logic                    sgn_o
);
   localparam int AMAX = (1 << (APP_W-1)) - 1;

   int diff;

   always_comb begin
      diff  = int'(app_i) - (ign_msg_i ? 0 : int'(msg_i));
      diff  = clamp_sym(diff, AMAX);
      v2c_o = APP_W'(diff);
      sgn_o = (diff < 0);
      mag_o = (APP_W-1)'((diff < 0) ? -diff : diff);
   end
endmodule

// File: rtl/cnb_min_merge.sv
module cnb_min_merge #(
   parameter int MAGW = 6,
   parameter int PW   = 4
) (
   input  logic            vld_i,
   input  logic [MAGW-1:0] mag_i,
   input  logic [PW-1:0]   pos_i,
   input  logic [MAGW-1:0] m1_i,
   input  logic [MAGW-1:0] m2_i,
   input  logic [PW-1:0]   idx_i,
   output logic [MAGW-1:0] m1_o,
   output logic [MAGW-1:0] m2_o,
   output logic [PW-1:0]   idx_o
);
   always_comb begin
      m1_o  = m1_i;
      m2_o  = m2_i;
      idx_o = idx_i;
      if (vld_i) begin
         if (mag_i < m1_i) begin
            m2_o  = m1_i;
            m1_o  = mag_i;
            idx_o = pos_i;
         end else if (mag_i < m2_i) begin
            m2_o = mag_i;
         end
      end
   end
endmodule

// File: rtl/cnb_c2c_out.sv
module cnb_c2c_out
   import cnb_pkg::*;
#(
   parameter int APP_W = 7,
   parameter int MSG_W = 6,
   parameter int NORM_SH = 3
) (
   input  logic                    vld_i,
   input  logic                    is_min_i,
   input  logic signed [APP_W-1:0] v2c_i,
   input  logic [APP_W-2:0]        m1_i,
   input  logic [APP_W-2:0]        m2_i,
   input  logic                    sgn_all_i,
   output logic signed [MSG_W-1:0] c2c_o,
   output logic signed [APP_W-1:0] app_o
);
   localparam int AMAX = (1 << (APP_W-1)) - 1;
   localparam int MMAX = (1 << (MSG_W-1)) - 1;

   int  mag, val, sum;
   logic neg;

   always_comb begin
      mag = int'(is_min_i ? m2_i : m1_i);
      mag = norm_mag(mag, NORM_SH);
      if (mag > MMAX) mag = MMAX;
      neg = sgn_all_i ^ v2c_i[APP_W-1];
      val = neg ? -mag : mag;
      sum = clamp_sym(int'(v2c_i) + val, AMAX);
      if (vld_i) begin
         c2c_o = MSG_W'(val);
         app_o = APP_W'(sum);
      end else begin
         c2c_o = '0;
         app_o = '0;
      end
   end
endmodule

// File: rtl/mslayer_cnb.sv
module mslayer_cnb
   import cnb_pkg::*;
#(
   parameter int NSLOT    = 3,
   parameter int APP_W    = 7,
   parameter int MSG_W    = 6,
   parameter int MAX_DEG  = 15,
   parameter int DEPTH    = 32,
   parameter int NORM_SH  = 3,
   parameter bit CLR_MEM  = 1'b1,
   localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_beat,
   input  logic                              in_start,
   input  logic                              in_end,
   input  logic                              in_first_iter,
   input  logic [AW-1:0]                     in_addr,
   input  logic [NSLOT-1:0]                  in_vld,
   input  logic [NSLOT-1:0][APP_W-1:0]       in_app,
   output logic                              out_beat,
   output logic                              out_end,
   output logic [NSLOT-1:0]                  out_vld,
   output logic [NSLOT-1:0][APP_W-1:0]       out_app,
   output logic [NSLOT-1:0][MSG_W-1:0]       out_c2c,
   output logic                              out_parity
);
   localparam int MAX_BEATS = (MAX_DEG + NSLOT - 1) / NSLOT;
   localparam int BW        = $clog2(MAX_BEATS + 1);
   localparam int NPOS      = MAX_BEATS * NSLOT;
   localparam int PW        = (NPOS > 1) ? $clog2(NPOS) : 1;
   localparam int MAGW      = APP_W - 1;

   // elaboration-time parameter checks
   if (APP_W < 3)        begin : g_chk_app  $error("APP_W too small");       end
   if (MSG_W >= APP_W)   begin : g_chk_msg  $error("MSG_W must be < APP_W"); end
   if (MSG_W < 2)        begin : g_chk_msg2 $error("MSG_W too small");       end
   if (NSLOT < 1)        begin : g_chk_sl   $error("NSLOT must be >= 1");    end
   if (MAX_DEG < NSLOT)  begin : g_chk_deg  $error("MAX_DEG below NSLOT");   end
   if (NORM_SH < 1)      begin : g_chk_sh   $error("NORM_SH must be >= 1");  end

   // per-edge message store
   logic signed [MSG_W-1:0] c2c_mem [DEPTH][NSLOT];

   // collection accumulators
   logic [MAGW-1:0] acc_m1, acc_m2;
   logic [PW-1:0]   acc_idx;
   logic            acc_sgn, acc_par;
   logic [BW-1:0]   acc_cnt;
   logic            col_bank;

   // ping-pong beat buffers
   logic signed [APP_W-1:0] buf_v2c  [2][MAX_BEATS][NSLOT];
   logic [NSLOT-1:0]        buf_vld  [2][MAX_BEATS];
   logic [AW-1:0]           buf_addr [2][MAX_BEATS];

   // latched check node result and replay control
   logic [MAGW-1:0] res_m1, res_m2;
   logic [PW-1:0]   res_idx;
   logic            res_sgn, res_par;
   logic            wb_act, wb_bank;
   logic [BW-1:0]   wb_ptr, wb_len;
   logic            wb_last;

   // ---------------- collection pass ----------------
   logic [MAGW-1:0] base_m1, base_m2;
   logic [PW-1:0]   base_idx;
   logic            base_sgn, base_par;
   logic [BW-1:0]   base_cnt;

   always_comb begin
      if (in_start) begin
         base_m1  = '1;
         base_m2  = '1;
         base_idx = '0;
         base_sgn = 1'b0;
         base_par = 1'b0;
         base_cnt = '0;
      end else begin
         base_m1  = acc_m1;
         base_m2  = acc_m2;
         base_idx = acc_idx;
         base_sgn = acc_sgn;
         base_par = acc_par;
         base_cnt = acc_cnt;
      end
   end

   logic signed [APP_W-1:0] col_v2c [NSLOT];
   logic [MAGW-1:0]         col_mag [NSLOT];
   logic                    col_sgn [NSLOT];
   logic [PW-1:0]           col_pos [NSLOT];
   logic [MAGW-1:0]         ch_m1   [NSLOT+1];
   logic [MAGW-1:0]         ch_m2   [NSLOT+1];
   logic [PW-1:0]           ch_idx  [NSLOT+1];

   assign ch_m1[0]  = base_m1;
   assign ch_m2[0]  = base_m2;
   assign ch_idx[0] = base_idx;

   for (genvar s = 0; s < NSLOT; s++) begin : g_col
      assign col_pos[s] = PW'(int'(base_cnt) * NSLOT + s);

      cnb_v2c #(.APP_W(APP_W), .MSG_W(MSG_W)) u_v2c (
         .app_i     (in_app[s]),
         .msg_i     (c2c_mem[in_addr][s]),
         .ign_msg_i (in_first_iter),
         .v2c_o     (col_v2c[s]),
         .mag_o     (col_mag[s]),
         .sgn_o     (col_sgn[s])
      );

      cnb_min_merge #(.MAGW(MAGW), .PW(PW)) u_merge (
         .vld_i (in_vld[s]),
         .mag_i (col_mag[s]),
         .pos_i (col_pos[s]),
         .m1_i  (ch_m1[s]),
         .m2_i  (ch_m2[s]),
         .idx_i (ch_idx[s]),
         .m1_o  (ch_m1[s+1]),
         .m2_o  (ch_m2[s+1]),
         .idx_o (ch_idx[s+1])
      );
   end

   logic nxt_sgn, nxt_par;
   always_comb begin
      nxt_sgn = base_sgn;
      nxt_par = base_par;
      for (int s = 0; s < NSLOT; s++) begin
         if (in_vld[s]) begin
            nxt_sgn = nxt_sgn ^ col_sgn[s];
            nxt_par = nxt_par ^ in_app[s][APP_W-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (in_beat) begin
         buf_addr[col_bank][base_cnt] <= in_addr;
         buf_vld[col_bank][base_cnt]  <= in_vld;
         for (int s = 0; s < NSLOT; s++)
            buf_v2c[col_bank][base_cnt][s] <= col_v2c[s];
      end
   end

   // ---------------- replay pass ----------------
   assign wb_last = wb_act && (wb_ptr == wb_len - BW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_m1   <= '1;
         acc_m2   <= '1;
         acc_idx  <= '0;
         acc_sgn  <= 1'b0;
         acc_par  <= 1'b0;
         acc_cnt  <= '0;
         col_bank <= 1'b0;
         res_m1   <= '1;
         res_m2   <= '1;
         res_idx  <= '0;
         res_sgn  <= 1'b0;
         res_par  <= 1'b0;
         wb_act   <= 1'b0;
         wb_bank  <= 1'b0;
         wb_ptr   <= '0;
         wb_len   <= '0;
      end else begin
         if (wb_act) begin
            if (wb_last) wb_act <= 1'b0;
            else         wb_ptr <= wb_ptr + BW'(1);
         end
         if (in_beat) begin
            acc_m1  <= ch_m1[NSLOT];
            acc_m2  <= ch_m2[NSLOT];
            acc_idx <= ch_idx[NSLOT];
            acc_sgn <= nxt_sgn;
            acc_par <= nxt_par;
            acc_cnt <= base_cnt + BW'(1);
            if (in_end) begin
               res_m1   <= ch_m1[NSLOT];
               res_m2   <= ch_m2[NSLOT];
               res_idx  <= ch_idx[NSLOT];
               res_sgn  <= nxt_sgn;
               res_par  <= nxt_par;
               wb_act   <= 1'b1;
               wb_ptr   <= '0;
               wb_len   <= base_cnt + BW'(1);
               wb_bank  <= col_bank;
               col_bank <= ~col_bank;
            end
         end
      end
   end

   logic [AW-1:0]           wb_addr;
   logic [NSLOT-1:0]        wb_vld;
   logic signed [MSG_W-1:0] wb_c2c [NSLOT];
   logic signed [APP_W-1:0] wb_app [NSLOT];

   assign wb_addr = buf_addr[wb_bank][wb_ptr];
   assign wb_vld  = wb_act ? buf_vld[wb_bank][wb_ptr] : '0;

   for (genvar s = 0; s < NSLOT; s++) begin : g_wb
      logic [PW-1:0] pos;
      assign pos = PW'(int'(wb_ptr) * NSLOT + s);

      cnb_c2c_out #(.APP_W(APP_W), .MSG_W(MSG_W), .NORM_SH(NORM_SH)) u_out (
         .vld_i     (wb_vld[s]),
         .is_min_i  (pos == res_idx),
         .v2c_i     (buf_v2c[wb_bank][wb_ptr][s]),
         .m1_i      (res_m1),
         .m2_i      (res_m2),
         .sgn_all_i (res_sgn),
         .c2c_o     (wb_c2c[s]),
         .app_o     (wb_app[s])
      );

      assign out_app[s] = wb_app[s];
      assign out_c2c[s] = wb_c2c[s];
   end

   // message store write-back, reset variant chosen by parameter
   if (CLR_MEM) begin : g_mem_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++)
               for (int s = 0; s < NSLOT; s++)
                  c2c_mem[a][s] <= '0;
         end else begin
            for (int s = 0; s < NSLOT; s++)
               if (wb_vld[s]) c2c_mem[wb_addr][s] <= wb_c2c[s];
         end
      end
   end else begin : g_mem_raw
      always_ff @(posedge clk) begin
         for (int s = 0; s < NSLOT; s++)
            if (wb_vld[s]) c2c_mem[wb_addr][s] <= wb_c2c[s];
      end
   end

   assign out_beat   = wb_act;
   assign out_end    = wb_last;
   assign out_vld    = wb_vld;
   assign out_parity = wb_last & res_par;

endmodule

// File: rtl/cnb_lane_chk.sv
module cnb_lane_chk #(
   parameter int NSLOT     = 3,
   parameter int APP_W     = 7,
   parameter int MSG_W     = 6,
   parameter int BW        = 3,
   parameter int MAX_BEATS = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_beat,
   input logic                        in_start,
   input logic                        in_end,
   input logic                        out_beat,
   input logic                        out_end,
   input logic [NSLOT-1:0]            out_vld,
   input logic [NSLOT-1:0][APP_W-1:0] out_app,
   input logic [NSLOT-1:0][MSG_W-1:0] out_c2c,
   input logic                        out_parity,
   input logic [BW-1:0]               acc_cnt,
   input logic                        wb_act,
   input logic [BW-1:0]               wb_ptr,
   input logic [BW-1:0]               wb_len
);
   localparam logic [APP_W-1:0] APP_NEG = {1'b1, {(APP_W-1){1'b0}}};
   localparam logic [MSG_W-1:0] MSG_NEG = {1'b1, {(MSG_W-1){1'b0}}};

   // R8
   end_starts_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_beat && in_end |=> out_beat);

   // R8
   replay_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_beat && !out_end |=> out_beat);

   // R8
   end_inside_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_end |-> out_beat);

   // R1
   quiet_without_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_beat |-> (out_vld == '0) && !out_parity);

   // R7
   parity_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_parity |-> out_end);

   // R10
   beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_beat && !in_start |-> int'(acc_cnt) < MAX_BEATS);

   // R10
   overlap_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_beat && in_end |-> !wb_act || (wb_ptr == wb_len - BW'(1)));

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      // R6
      idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_vld[s] |-> (out_app[s] == '0) && (out_c2c[s] == '0));

      // R11
      sym_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[s] |-> (out_app[s] != APP_NEG) && (out_c2c[s] != MSG_NEG));
   end
endmodule

bind mslayer_cnb cnb_lane_chk #(
   .NSLOT(NSLOT), .APP_W(APP_W), .MSG_W(MSG_W), .BW(BW), .MAX_BEATS(MAX_BEATS)
) u_lane_chk (
   .clk(clk), .rst_n(rst_n), .in_beat(in_beat), .in_start(in_start), .in_end(in_end),
   .out_beat(out_beat), .out_end(out_end), .out_vld(out_vld), .out_app(out_app),
   .out_c2c(out_c2c), .out_parity(out_parity), .acc_cnt(acc_cnt), .wb_act(wb_act),
   .wb_ptr(wb_ptr), .wb_len(wb_len)
);

// File: tb/test_mslayer_cnb.sv
module test_mslayer_cnb;
   localparam int NS = 3, AW_ = 7, MW = 6, DEP = 32, NCHK = 6, ROUNDS = 40, NREC = 2048;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_beat = 0, in_start = 0, in_end = 0, in_first_iter = 0;
   logic [4:0] in_addr = '0;
   logic [NS-1:0] in_vld = '0;
   logic [NS-1:0][AW_-1:0] in_app = '0;
   logic out_beat, out_end, out_parity;
   logic [NS-1:0] out_vld;
   logic [NS-1:0][AW_-1:0] out_app;
   logic [NS-1:0][MW-1:0] out_c2c;

   mslayer_cnb i_mslayer_cnb (
      .clk(clk), .rst_n(rst_n), .in_beat(in_beat), .in_start(in_start), .in_end(in_end),
      .in_first_iter(in_first_iter), .in_addr(in_addr), .in_vld(in_vld), .in_app(in_app),
      .out_beat(out_beat), .out_end(out_end), .out_vld(out_vld), .out_app(out_app),
      .out_c2c(out_c2c), .out_parity(out_parity));

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // expected replay records
   int e_cyc [NREC];
   int e_app [NREC][NS];
   int e_c2c [NREC][NS];
   bit e_vld [NREC][NS];
   bit e_end [NREC];
   bit e_par [NREC];
   int wptr = 0, rptr = 0;

   int mdl_mem [DEP][NS];

   function automatic int clampi(input int x, input int l);
      return (x > l) ? l : ((x < -l) ? -l : x);
   endfunction

   task automatic idle_cycle();
      @(negedge clk);
      in_beat  = 0;
      in_start = 1'($urandom_range(0, 1));
      in_end   = 1'($urandom_range(0, 1));
      in_vld   = NS'($urandom_range(0, 7));
      for (int s = 0; s < NS; s++) in_app[s] = AW_'($urandom_range(0, 127));
   endtask

   int prev_end = -100, prev_m = 0;

   task automatic run_check(input int r, input int c, input int d, input bit first);
      bit vld [5][NS];
      int app [5][NS];
      int v   [5][NS];
      int nb, nidle, m1, m2, idx, sgall, par, mode, base;
      nb = (d + NS - 1) / NS;
      nidle = nb * NS - d;
      mode = r % 4;
      for (int k = 0; k < nb; k++)
         for (int s = 0; s < NS; s++) begin
            vld[k][s] = 1;
            case (mode)
               1: app[k][s] = (($urandom_range(0, 1) == 1) ? -1 : 1) * (20 + (r % 7));
               2: begin
                     case ($urandom_range(0, 3))
                        0: app[k][s] = -64;
                        1: app[k][s] = 63;
                        2: app[k][s] = -63;
                        default: app[k][s] = 0;
                     endcase
                  end
               default: app[k][s] = int'($urandom_range(0, 127)) - 64;
            endcase
         end
      while (nidle > 0) begin
         int p = $urandom_range(0, nb * NS - 1);
         if (vld[p / NS][p % NS]) begin
            vld[p / NS][p % NS] = 0;
            app[p / NS][p % NS] = int'($urandom_range(0, 127)) - 64; // garbage, R6
            nidle--;
         end
      end
      // model: collection pass (R2, R3, R4, R7)
      m1 = 63; m2 = 63; idx = -1; sgall = 0; par = 0;
      for (int k = 0; k < nb; k++)
         for (int s = 0; s < NS; s++)
            if (vld[k][s]) begin
               v[k][s] = clampi(app[k][s] - (first ? 0 : mdl_mem[c * 5 + k][s]), 63);
               if ((v[k][s] < 0 ? -v[k][s] : v[k][s]) < m1) begin
                  m2 = m1; m1 = (v[k][s] < 0 ? -v[k][s] : v[k][s]); idx = k * NS + s;
               end else if ((v[k][s] < 0 ? -v[k][s] : v[k][s]) < m2)
                  m2 = (v[k][s] < 0 ? -v[k][s] : v[k][s]);
               sgall ^= (v[k][s] < 0);
               par ^= (app[k][s] < 0);
            end
      // model: replay pass (R3, R4, R5, R9)
      base = wptr;
      for (int k = 0; k < nb; k++) begin
         for (int s = 0; s < NS; s++) begin
            e_vld[wptr][s] = vld[k][s];
            e_app[wptr][s] = 0;
            e_c2c[wptr][s] = 0;
            if (vld[k][s]) begin
               int mg, cv;
               mg = (k * NS + s == idx) ? m2 : m1;
               mg = mg - (mg >>> 3);
               if (mg > 31) mg = 31;
               cv = ((sgall ^ (v[k][s] < 0 ? 1 : 0)) != 0) ? -mg : mg;
               e_c2c[wptr][s] = cv;
               e_app[wptr][s] = clampi(v[k][s] + cv, 63);
               mdl_mem[c * 5 + k][s] = cv;
            end
         end
         e_end[wptr] = (k == nb - 1);
         e_par[wptr] = (k == nb - 1) ? par[0] : 1'b0;
         e_cyc[wptr] = -1;
         wptr++;
      end
      // drive
      for (int k = 0; k < nb; k++) begin
         if ($urandom_range(0, 7) == 0) idle_cycle();          // R8 gap
         if (k == nb - 1)
            while (cyc < prev_end + prev_m) idle_cycle();       // R10 spacing
         @(negedge clk);
         in_beat = 1; in_start = (k == 0); in_end = (k == nb - 1);
         in_first_iter = first;
         in_addr = 5'(c * 5 + k);
         for (int s = 0; s < NS; s++) begin
            in_vld[s] = vld[k][s];
            in_app[s] = AW_'(app[k][s]);
         end
         if (k == nb - 1) begin
            for (int j = 0; j < nb; j++) e_cyc[base + j] = cyc + 1 + j;
            prev_end = cyc; prev_m = nb;
         end
      end
   endtask

   // monitor, sampled 5 ns after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n && out_beat) begin
            if (rptr >= wptr) begin
               chk("R8 spurious beat", 1, 0);
            end else begin
               chk("R8 beat cycle", cyc, e_cyc[rptr]);
               chk("R8 end flag", int'(out_end), int'(e_end[rptr]));
               chk("R7 parity", int'(out_parity), int'(e_par[rptr]));
               for (int s = 0; s < NS; s++) begin
                  chk("R6 slot valid", int'(out_vld[s]), int'(e_vld[rptr][s]));
                  chk("R3 R4 message", int'($signed(out_c2c[s])), e_c2c[rptr][s]);
                  chk("R5 R2 app", int'($signed(out_app[s])), e_app[rptr][s]);
               end
               rptr++;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired act=%0d exp=%0d", rptr, wptr);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < DEP; a++)
         for (int s = 0; s < NS; s++) mdl_mem[a][s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1 out_beat", int'(out_beat), 0);
      chk("R1 out_end", int'(out_end), 0);
      chk("R1 out_vld", int'(out_vld), 0);
      chk("R1 out_parity", int'(out_parity), 0);
      for (int r = 0; r < ROUNDS; r++) begin
         // round 0 relies on the cleared store (R1, R9); some rounds ignore it (R2)
         bit first = (r % 5 == 3);
         if (r % 6 == 0) repeat (3) idle_cycle();
         for (int c = 0; c < NCHK; c++)
            run_check(r, c, 5 + ((c * 4 + r * 3) % 11), first);
      end
      idle_cycle();
      in_start = 0; in_end = 0;
      repeat (12) @(negedge clk);
      chk("R8 all beats replayed", rptr, wptr);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule